// File: doc/BRIEF.md
# Dual-Clock Video Field Buffer Controller

This block is a first-in-first-out store for video fields. Bytes are written into it on one clock, in order, and read back on an unrelated clock at a different rate. Each side keeps its own address pointer, and each has three controls: a transfer enable, a gate and a pointer-clear pulse. On the write side, a closed gate leaves the addressed word unchanged but still steps the pointer past it. This lets a new field be laid over an old one while chosen pixels keep their previous values. On the read side, a closed gate steps over a word without presenting it, so the output register holds its last value.

Two flags show the fill state: one says there is room to write, the other says there is data to read. Each pointer crosses into the other clock domain as a Gray code through a two-flop synchroniser, and the flags are formed from the synchronised copy. One strap input sets the active level of all six controls, so the block fits boards that use either convention. The storage depth is a parameter. A full-size field store needs 19 address bits, and smaller values are used for simulation.

Top module: `field_fifo_ctrl`

## Requirements
- R1: After the synchronous resets `wrst` and `rrst` are applied, `in_ready` is 1, `out_ready` is 0 and `rdata` is 0.
- R2: Words that are stored come out of `rdata` in the order in which they were written.
- R3: A write cycle issued while `in_ready` is 0 stores nothing and does not move the write pointer.
- R4: A read cycle issued while `out_ready` is 0 does not move the read pointer, and `rdata` is unchanged.
- R5: A write cycle whose gate is inactive leaves the addressed word holding its previous content and still advances the write pointer by one.
- R6: A read cycle whose gate is inactive advances the read pointer by one, and `rdata` keeps its previous value.
- R7: A control input is active when it differs from `pol_strap`: with `pol_strap` = 1 the controls are active low, and with `pol_strap` = 0 they are active high.
- R8: An active pointer-clear pulse sets that side's pointer to location 0 on the next edge of its clock. The pulse overrides that side's enable and stores or presents nothing in that cycle.
- R9: `rdata` shows the word at the read pointer one `rclk` edge after an enabled, gated read cycle.
- R10: A write becomes visible to the read side through a two-stage synchroniser. With equal clocks, `out_ready` rises after the second clock edge that follows the edge that moved the write pointer. Room freed by a read reaches `in_ready` through the same two-stage path.
- R11: With no reads, `in_ready` falls after exactly 2**`ADDR_W` accepted write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| pol_strap | input | 1 | Control polarity: 1 means active low, 0 means active high |
| w_en | input | 1 | Write cycle enable |
| w_gate | input | 1 | Write gate; when inactive, the old word is kept |
| w_ptr_clr | input | 1 | Write pointer clear pulse |
| wdata | input | DATA_W | Write data |
| in_ready | output | 1 | Room available for a write |
| r_en | input | 1 | Read cycle enable |
| r_gate | input | 1 | Read gate; when inactive, the word is skipped |
| r_ptr_clr | input | 1 | Read pointer clear pulse |
| rdata | output | DATA_W | Registered read data |
| out_ready | output | 1 | At least one word available to read |

## Verification
The bench builds the block with `ADDR_W` = 4, which gives a 16-word store. This brings the full boundary within reach after a few dozen cycles, so pointer wrap-around and the transient flag states after a pointer clear are also reached. Both ports run on one shared clock. This fixes the synchroniser delay at exactly two edges, so the reference model can predict both flags cycle for cycle. A second pass with the strap inverted repeats the traffic with active-low controls.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  // Decoded (active-high) controls of one port
  typedef struct packed {
    logic en;
    logic gate;
    logic clr;
  } port_ctl_t;

  // A pin is active when it differs from the strap level
  function automatic port_ctl_t decode_ctl(input logic en_pin, input logic gate_pin,
                                           input logic clr_pin, input logic strap);
    port_ctl_t c;
    c.en   = en_pin ^ strap;
    c.gate = gate_pin ^ strap;
    c.clr  = clr_pin ^ strap;
    return c;
  endfunction

endpackage

// File: rtl/ffc_sync.sv
module ffc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ffc_wr_side.sv
module ffc_wr_side
  import ffc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic              in_ready
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] wptr, wptr_nxt;
  logic          full, step;

  // Full when the pointers differ by exactly the depth (top two Gray bits inverted)
  assign full     = (wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
  assign in_ready = ~full;
  assign step     = ctl.en & ~full & ~ctl.clr;
  assign we       = step & ctl.gate;
  assign waddr    = wptr[ADDR_W-1:0];

  always_comb begin
    if (ctl.clr)   wptr_nxt = '0;
    else if (step) wptr_nxt = wptr + 1'b1;
    else           wptr_nxt = wptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !ctl.clr) |=> (wptr == $past(wptr)));

  p_wclr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.clr |=> (wptr == '0 && wgray == '0));

  p_wgray_step_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl.clr |=> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/ffc_rd_side.sv
module ffc_rd_side
  import ffc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              re,
  output logic              out_ready
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rptr, rptr_nxt;
  logic          empty, step;

  assign empty     = (rgray == wgray_sync);
  assign out_ready = ~empty;
  assign step      = ctl.en & ~empty & ~ctl.clr;
  assign re        = step & ctl.gate;
  assign raddr     = rptr[ADDR_W-1:0];

  always_comb begin
    if (ctl.clr)   rptr_nxt = '0;
    else if (step) rptr_nxt = rptr + 1'b1;
    else           rptr_nxt = rptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= rptr_nxt ^ (rptr_nxt >> 1);
    end
  end

  p_empty_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && !ctl.clr) |=> (rptr == $past(rptr)));

  p_rclr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.clr |=> (rptr == '0 && rgray == '0));

  p_rgray_step_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl.clr |=> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/ffc_ram.sv
module ffc_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  p_rdata_hold_r6: assert property (@(posedge rclk) disable iff (rrst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/field_fifo_ctrl.sv
module field_fifo_ctrl
  import ffc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              pol_strap,
  input  logic              w_en,
  input  logic              w_gate,
  input  logic              w_ptr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_ready,
  input  logic              r_en,
  input  logic              r_gate,
  input  logic              r_ptr_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              out_ready
);
  localparam int PW = ADDR_W + 1;

  port_ctl_t         wctl, rctl;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re;

  assign wctl = decode_ctl(w_en, w_gate, w_ptr_clr, pol_strap);
  assign rctl = decode_ctl(r_en, r_gate, r_ptr_clr, pol_strap);

  ffc_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wclk), .rst(wrst), .ctl(wctl), .rgray_sync(rgray_s),
    .wgray(wgray), .waddr(waddr), .we(we), .in_ready(in_ready));

  ffc_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rclk), .rst(rrst), .ctl(rctl), .wgray_sync(wgray_s),
    .rgray(rgray), .raddr(raddr), .re(re), .out_ready(out_ready));

  ffc_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));
  ffc_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s));

  ffc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(rrst), .re(re), .raddr(raddr), .rdata(rdata));

  p_mask_nostore_r5: assert property (@(posedge wclk) disable iff (wrst)
    !wctl.gate |-> !we);

  p_skip_noload_r6: assert property (@(posedge rclk) disable iff (rrst)
    !rctl.gate |-> !re);
endmodule

// File: tb/sim_field_fifo_ctrl.sv
module sim_field_fifo_ctrl;
  localparam int AW = 4;
  localparam int D  = 1 << AW;
  localparam int P  = 2 * D;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, strap = 1'b0;
  logic lw_en = 0, lw_g = 0, lw_c = 0, lr_en = 0, lr_g = 0, lr_c = 0;
  logic [7:0] wdata = 8'h00;
  logic in_ready, out_ready;
  logic [7:0] rdata;

  field_fifo_ctrl #(.ADDR_W(AW), .DATA_W(8)) u0 (
    .wclk(clk), .wrst(rst), .rclk(clk), .rrst(rst), .pol_strap(strap),
    .w_en(lw_en ^ strap), .w_gate(lw_g ^ strap), .w_ptr_clr(lw_c ^ strap),
    .wdata(wdata), .in_ready(in_ready),
    .r_en(lr_en ^ strap), .r_gate(lr_g ^ strap), .r_ptr_clr(lr_c ^ strap),
    .rdata(rdata), .out_ready(out_ready));

  int tests = 0, fails = 0;
  string cur = "R1";
  bit cmp_on = 0;

  // Reference model: integer pointers modulo 2*depth, two-deep sync history
  int mem_m [D];
  int wp = 0, rp = 0, wps1 = 0, wps2 = 0, rps1 = 0, rps2 = 0;
  logic [7:0] rd_m = 8'h00;

  function automatic bit m_full();
    return ((wp - rps2 + P) % P) == D;
  endfunction
  function automatic bit m_empty();
    return rp == wps2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      wp = 0; rp = 0; wps1 = 0; wps2 = 0; rps1 = 0; rps2 = 0; rd_m = 8'h00;
    end else begin
      bit f, e;
      int nwp, nrp;
      f = m_full(); e = m_empty();
      nwp = wp; nrp = rp;
      if (lr_c) nrp = 0;
      else if (lr_en && !e) begin
        if (lr_g) rd_m = mem_m[rp % D][7:0];
        nrp = (rp + 1) % P;
      end
      if (lw_c) nwp = 0;
      else if (lw_en && !f) begin
        if (lw_g) mem_m[wp % D] = int'(wdata);
        nwp = (wp + 1) % P;
      end
      wps2 = wps1; wps1 = wp;
      rps2 = rps1; rps1 = rp;
      wp = nwp; rp = nrp;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur, " in_ready"},  {31'b0, in_ready},  {31'b0, ~m_full()});
      chk({cur, " out_ready"}, {31'b0, out_ready}, {31'b0, ~m_empty()});
      chk({cur, " rdata"},     {24'b0, rdata},     {24'b0, rd_m});
    end
  end

  task automatic cyc(input logic we, input logic wg, input logic wc,
                     input logic re, input logic rg, input logic rc, input logic [7:0] d);
    @(negedge clk);
    lw_en = we; lw_g = wg; lw_c = wc; lr_en = re; lr_g = rg; lr_c = rc; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    cmp_on = 0; rst = 1; strap = s;
    lw_en = 0; lw_g = 0; lw_c = 0; lr_en = 0; lr_g = 0; lr_c = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state checked explicitly
    chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
    chk("R1 out_ready", {31'b0, out_ready}, 32'd0);
    chk("R1 rdata", {24'b0, rdata}, 32'd0);
    cmp_on = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    cur = "R10";
    cyc(1, 1, 0, 0, 0, 0, 8'h11);
    idle(4);
    cur = "R2";
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 8'h20 + 8'(i));
    idle(3);
    cur = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 1, 0, 8'h00);
    idle(3);
    cur = "R11";
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, 0, 8'(i * 37 + 5));
    cur = "R3";
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 8'hEE);
    cur = "R4";
    for (int i = 0; i < 22; i++) cyc(0, 0, 0, 1, 1, 0, 8'h00);
    idle(3);
    cur = "R8";
    cyc(0, 0, 1, 0, 0, 1, 8'h00);
    idle(4);
    cur = "R5";
    for (int i = 0; i < 16; i++) cyc(1, (i % 2) == 0, 0, 0, 0, 0, 8'hA0 + 8'(i));
    idle(3);
    cur = "R6";
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, (i % 3) != 1, 0, 8'h00);
    idle(3);
    cur = "R8";
    cyc(1, 1, 1, 1, 1, 1, 8'h55);
    idle(4);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 0, 8'h60 + 8'(i));
    idle(3);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, 8'h00);
    cyc(0, 0, 0, 1, 1, 1, 8'h00);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 1, 0, 8'h00);
    idle(3);
    cur = "R2";
    for (int i = 0; i < 60; i++)
      cyc((i % 3) != 0, (i % 5) != 2, 0, (i % 2) == 0, (i % 7) != 3, 0, 8'(i * 13 + 1));
    idle(4);
    do_reset(1'b1);
    cur = "R7";
    for (int i = 0; i < 10; i++) cyc(1, (i % 4) != 3, 0, 0, 0, 0, 8'hC0 + 8'(i));
    idle(3);
    for (int i = 0; i < 40; i++)
      cyc((i % 2) == 0, 1, 0, (i % 3) != 0, (i % 5) != 0, 0, 8'(i * 7 + 3));
    idle(4);
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule